// File: doc/BRIEF.md
# Serial Configuration Slave for an LCD Bias Controller

This block is the digital control side of an LCD bias supply. It acts as a target on a two-wire SMBus and answers one fixed 7-bit address. A host can send a single data byte to it, or read back a single status byte. Each data byte carries a bank-select bit, two configuration bits (a run/stop bit and an LCD-enable bit), and a 5-bit DAC code. The configuration bits go into one of two banks: the operating bank or the suspend bank. The DAC code is shared by both banks and is rewritten by every accepted byte.

An external suspend pin chooses which bank drives the outputs. The block produces three results from the active bank, the stored DAC code and a power-good comparator input: a shutdown flag, a pull-low drive for the open-drain LCD-enable line, and the DAC code. SCL and SDA are sampled with the system clock. The block answers by pulling SDA low through an open-drain drive output. The serial interface keeps working while the supply is shut down, so a host can always write the part back into operation.

Top module: `lcdbias_smb_cfg`

## Requirements
- R1: The block acknowledges only address 7'b0101100, by pulling SDA low during the ninth clock. For any other address it leaves SDA released and ignores the rest of the transfer, so no output changes.
- R2: A write data byte is decoded as follows: bit 7 selects the bank, bit 6 is the run bit (1 = operating, 0 = shutdown), bit 5 is the LCD-enable bit, and bits 4:0 are the DAC code with bit 4 as the MSB. The DAC code appears on `dac_code_o`.
- R3: When bit 7 is 1, bits 6:5 load the operating bank. When bit 7 is 0, they load the suspend bank. The other bank keeps its value, and the DAC code is loaded in both cases.
- R4: While `susp_n_i` is high, the operating bank is active. While it is low, the suspend bank is active. A change on the pin reaches the outputs in the same cycle.
- R5: `shdn_o` is 1 exactly when the run bit of the active bank is 0.
- R6: After reset, the operating bank holds run=1 and LCD=1, the suspend bank holds run=0 and LCD=0, the DAC code is 5'b10000, and SDA is released.
- R7: The DAC code does not change when the block enters or leaves shutdown, or when the active bank changes.
- R8: A read returns the status byte MSB first, after the address acknowledge. Bit 7 is 1 only when `pgood_i` is 1 and the block is not shut down. Bits 6:5 read as 0. Bits 4:0 return the DAC code.
- R9: `lcd_pull_o` is 1 only when `pgood_i` is 1, the active LCD-enable bit is 1 and the block is not shut down.
- R10: A write is accepted while the block is shut down, and it can set the active run bit back to 1.
- R11: A START seen in the middle of a transfer abandons that transfer and begins a new address phase. A STOP or START that arrives before the data acknowledge leaves every register unchanged.
- R12: A write changes the registers only after the acknowledge clock of the data byte has ended. No output changes earlier in the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain drive) |
| susp_n_i | input | 1 | Suspend pin: high selects the operating bank, low selects the suspend bank |
| pgood_i | input | 1 | Power-good comparator result |
| shdn_o | output | 1 | 1 = supply shut down |
| lcd_pull_o | output | 1 | 1 = pull the LCD-enable line low (LCD on) |
| dac_code_o | output | 5 | DAC code |

## Verification
Each bus edge passes through two synchronizer stages and one edge register. The engine therefore reacts three clocks after SCL or SDA moves, and a write reaches the outputs one clock after the falling edge of the data acknowledge clock is seen. The suspend pin and power-good reach `shdn_o` and `lcd_pull_o` combinationally, in the same cycle. The bench holds every bus phase for ten clocks, which leaves room for these delays. Its reference model compares all three results on every falling clock edge. The comparison is masked only across the acknowledge bit of a data byte, where the update is due, so any earlier change counts as an error.

// File: rtl/lcdbias_pkg.sv
package lcdbias_pkg;

    localparam int BYTE_W = 8;
    localparam int DAC_W  = 5;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [6:0] SLAVE_ADDR = 7'b0101100;
    localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_e;

    typedef struct packed {
        logic run;
        logic lcd;
    } bank_t;

    typedef struct packed {
        logic             sel;
        bank_t            bank;
        logic [DAC_W-1:0] code;
    } wr_byte_t;

    localparam bank_t OPR_RST = '{run: 1'b1, lcd: 1'b1};
    localparam bank_t SUS_RST = '{run: 1'b0, lcd: 1'b0};

    function automatic logic [BYTE_W-1:0] make_status(
        input logic             pg,
        input logic             down,
        input logic [DAC_W-1:0] code
    );
        return {pg & ~down, 2'b00, code};
    endfunction

endpackage

// File: rtl/lcdbias_line_sync.sv
module lcdbias_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], raw_i[g]};
            end
            assign sync_o[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/lcdbias_smb_engine.sv
module lcdbias_smb_engine
    import lcdbias_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_pull_o,
    output logic              wr_en_o,
    output wr_byte_t          wr_byte_o
);

    logic scl_q, sda_q;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              got8;
    logic              rw;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            got8       <= 1'b0;
            rw         <= 1'b0;
            sh         <= '0;
            sda_pull_o <= 1'b0;
            wr_en_o    <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det) begin
                state      <= ST_ADDR;
                cnt        <= '0;
                got8       <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (stop_det) begin
                state      <= ST_IDLE;
                got8       <= 1'b0;
                sda_pull_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + CNT_W'(1);
                            if (cnt == LAST_BIT) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (sh[BYTE_W-1:1] == SLAVE_ADDR) begin
                                    rw         <= sh[0];
                                    state      <= ST_ADDR_ACK;
                                    sda_pull_o <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state      <= ST_WDATA_ACK;
                                sda_pull_o <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                sh         <= status_i;
                                sda_pull_o <= ~status_i[BYTE_W-1];
                                state      <= ST_RDATA;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            wr_en_o    <= 1'b1;
                            sda_pull_o <= 1'b0;
                            state      <= ST_IDLE;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_RDATA_ACK;
                            end else begin
                                cnt        <= cnt + CNT_W'(1);
                                sh         <= {sh[BYTE_W-2:0], 1'b0};
                                sda_pull_o <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_fall) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign wr_byte_o = wr_byte_t'(sh);

    // R1: while acknowledging a matched address the line is held low
    assert_addr_ack_drive_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_ACK) |-> sda_pull_o);

    // R11: an idle or aborted engine never holds the data line
    assert_idle_release_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull_o);

    // R12: a commit is issued only as the transfer closes
    assert_commit_closes_R12: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (state == ST_IDLE));

endmodule

// File: rtl/lcdbias_cfg_regs.sv
module lcdbias_cfg_regs
    import lcdbias_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  wr_byte_t          wr_byte_i,
    input  logic              susp_n_i,
    input  logic              pgood_i,
    output logic              shdn_o,
    output logic              lcd_pull_o,
    output logic [DAC_W-1:0]  dac_o,
    output logic [BYTE_W-1:0] status_o
);

    bank_t            opr_q, sus_q, act;
    logic [DAC_W-1:0] dac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            opr_q <= OPR_RST;
            sus_q <= SUS_RST;
            dac_q <= DAC_MID;
        end else if (wr_en_i) begin
            if (wr_byte_i.sel) opr_q <= wr_byte_i.bank;
            else               sus_q <= wr_byte_i.bank;
            dac_q <= wr_byte_i.code;
        end
    end

    assign act        = susp_n_i ? opr_q : sus_q;
    assign shdn_o     = ~act.run;
    assign lcd_pull_o = pgood_i & act.lcd & act.run;
    assign dac_o      = dac_q;
    assign status_o   = make_status(pgood_i, shdn_o, dac_q);

    // R7: code survives shutdown and bank changes
    assert_dac_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(dac_q));

    // R3: a write aimed at one bank leaves the other alone
    assert_bank_opr_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_byte_i.sel) |=> $stable(sus_q));
    assert_bank_sus_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_byte_i.sel) |=> $stable(opr_q));

    // R9: the LCD line is never pulled while shut down
    assert_lcd_gate_R9: assert property (@(posedge clk) disable iff (rst)
        lcd_pull_o |-> (!shdn_o && pgood_i));

endmodule

// File: rtl/lcdbias_smb_cfg.sv
module lcdbias_smb_cfg
    import lcdbias_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             susp_n_i,
    input  logic             pgood_i,
    output logic             shdn_o,
    output logic             lcd_pull_o,
    output logic [DAC_W-1:0] dac_code_o
);

    logic [1:0]        sync_lines;
    logic              wr_en;
    wr_byte_t          wr_byte;
    logic [BYTE_W-1:0] status;

    lcdbias_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (sync_lines)
    );

    lcdbias_smb_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .scl_s      (sync_lines[1]),
        .sda_s      (sync_lines[0]),
        .status_i   (status),
        .sda_pull_o (sda_pull_o),
        .wr_en_o    (wr_en),
        .wr_byte_o  (wr_byte)
    );

    lcdbias_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_byte_i  (wr_byte),
        .susp_n_i   (susp_n_i),
        .pgood_i    (pgood_i),
        .shdn_o     (shdn_o),
        .lcd_pull_o (lcd_pull_o),
        .dac_o      (dac_code_o),
        .status_o   (status)
    );

endmodule

// File: tb/lcdbias_smb_cfg_tb.sv
module lcdbias_smb_cfg_tb;

    localparam int Q = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic susp_n = 1'b1, pgood = 1'b1;
    logic sda_pull, shdn, lcd_pull;
    logic [4:0] dac;
    wire  sda_line = sda_drv & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    bit mo_run = 1'b1, mo_lcd = 1'b1, ms_run = 1'b0, ms_lcd = 1'b0;
    int m_dac = 16;

    lcdbias_smb_cfg u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .susp_n_i   (susp_n),
        .pgood_i    (pgood),
        .shdn_o     (shdn),
        .lcd_pull_o (lcd_pull),
        .dac_code_o (dac)
    );

    function automatic bit e_run();
        return susp_n ? mo_run : ms_run;
    endfunction
    function automatic bit e_lcd();
        return pgood && e_run() && (susp_n ? mo_lcd : ms_lcd);
    endfunction
    function automatic int e_status();
        return ((pgood && e_run()) ? 128 : 0) + m_dac;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-clock reference comparison (R4 R5 R9, and R12 via no early change)
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk(shdn == !e_run(), "R5", "shdn_o", shdn, !e_run());
            chk(lcd_pull == e_lcd(), "R9", "lcd_pull_o", lcd_pull, e_lcd());
            chk(dac == m_dac[4:0], "R12", "dac_code_o", dac, m_dac);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bitc(input bit b, output bit r);
        sda_drv = b;  tick(Q);
        scl_drv = 1'b1; tick(Q);
        r = sda_line; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic start_c();
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic stop_c();
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic apply(input logic [7:0] db);
        if (db[7]) begin mo_run = db[6]; mo_lcd = db[5]; end
        else       begin ms_run = db[6]; ms_lcd = db[5]; end
        m_dac = db[4:0];
    endtask

    task automatic write_body(input logic [7:0] ab, input logic [7:0] db, input bit exp_ack, input string req);
        bit r, a;
        for (int i = 7; i >= 0; i--) bitc(ab[i], r);
        bitc(1'b1, a);
        chk(a == !exp_ack, "R1", "address ack level", a, !exp_ack);
        for (int i = 7; i >= 0; i--) bitc(db[i], r);
        cmp_en = 1'b0;
        bitc(1'b1, a);
        chk(a == !exp_ack, req, "data ack level", a, !exp_ack);
        if (exp_ack) apply(db);
        tick(2);
        cmp_en = 1'b1;
    endtask

    task automatic write_xfer(input logic [7:0] db, input string req);
        start_c();
        write_body(8'h58, db, 1'b1, req);
        stop_c();
    endtask

    task automatic read_xfer(input string req);
        bit r, a;
        logic [7:0] v;
        int exp;
        exp = e_status();
        start_c();
        for (int i = 7; i >= 0; i--) bitc(logic'(8'h59 >> i), r);
        bitc(1'b1, a);
        chk(a == 1'b0, "R1", "read address ack", a, 0);
        for (int i = 7; i >= 0; i--) begin
            bitc(1'b1, r);
            v[i] = r;
        end
        bitc(1'b1, a);
        stop_c();
        chk(v == exp[7:0], req, "status byte", v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit r, a;
        tick(5);
        rst = 1'b0;
        @(negedge clk);
        // R6: reset state
        chk(shdn == 1'b0, "R6", "reset shdn_o", shdn, 0);
        chk(lcd_pull == 1'b1, "R6", "reset lcd_pull_o", lcd_pull, 1);
        chk(dac == 5'd16, "R6", "reset dac_code_o", dac, 16);
        chk(sda_pull == 1'b0, "R6", "reset sda_pull_o", sda_pull, 0);
        cmp_en = 1'b1;
        read_xfer("R6");

        // R2 R3: operating bank, run=1 lcd=0 code 5
        write_xfer(8'hC5, "R2");
        chk(dac == 5'd5, "R2", "code after write", dac, 5);
        chk(lcd_pull == 1'b0, "R3", "operating lcd cleared", lcd_pull, 0);

        // R3 R4: suspend bank loaded, only visible with pin low
        write_xfer(8'h7F, "R3");
        chk(lcd_pull == 1'b0, "R4", "operating bank still active", lcd_pull, 0);
        susp_n = 1'b0; tick(2);
        chk(lcd_pull == 1'b1, "R4", "suspend bank active", lcd_pull, 1);
        chk(dac == 5'd31, "R3", "code from suspend write", dac, 31);

        // R5 R8 R7: shutdown through suspend bank
        write_xfer(8'h03, "R5");
        chk(shdn == 1'b1, "R5", "shutdown flag", shdn, 1);
        read_xfer("R8");
        susp_n = 1'b1; tick(2);
        chk(shdn == 1'b0, "R7", "operating after bank switch", shdn, 0);
        chk(dac == 5'd3, "R7", "code kept over switch", dac, 3);

        // R10: write during shutdown restores operation
        susp_n = 1'b0; tick(2);
        chk(shdn == 1'b1, "R10", "shut down before write", shdn, 1);
        write_xfer(8'h6A, "R10");
        chk(shdn == 1'b0, "R10", "running after write", shdn, 0);
        chk(dac == 5'd10, "R10", "code after write", dac, 10);

        // R1: foreign address ignored
        start_c();
        write_body(8'h5A, 8'h00, 1'b0, "R1");
        stop_c();
        chk(dac == 5'd10, "R1", "code after foreign address", dac, 10);

        // R11: STOP inside data byte
        start_c();
        for (int i = 7; i >= 0; i--) bitc(logic'(8'h58 >> i), r);
        bitc(1'b1, a);
        for (int i = 7; i >= 4; i--) bitc(logic'(8'h9F >> i), r);
        stop_c();
        chk(dac == 5'd10, "R11", "code after stop abort", dac, 10);

        // R11: repeated START inside data byte, then full write
        start_c();
        for (int i = 7; i >= 0; i--) bitc(logic'(8'h58 >> i), r);
        bitc(1'b1, a);
        for (int i = 0; i < 3; i++) bitc(1'b0, r);
        start_c();
        write_body(8'h58, 8'hE1, 1'b1, "R11");
        stop_c();
        chk(dac == 5'd1, "R11", "code after restarted write", dac, 1);
        susp_n = 1'b1; tick(2);
        chk(lcd_pull == 1'b1, "R4", "operating bank lcd on", lcd_pull, 1);

        // R9 R8: power-good low gates LCD and status
        pgood = 1'b0; tick(2);
        chk(lcd_pull == 1'b0, "R9", "lcd with power-good low", lcd_pull, 0);
        read_xfer("R8");

        // R8: shutdown masks status bit with power-good high
        pgood = 1'b1;
        write_xfer(8'h80, "R8");
        read_xfer("R8");
        tick(4);

        cmp_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule